// File: doc/BRIEF.md
# Serial Audio Slot Receiver

This block turns a two-slot serial audio stream into parallel samples. An external source supplies the bit clock, the word-select line and the serial data line. The block brings all three into the system clock domain and finds each rising edge of the bit clock. It then takes the slot boundaries from the word-select transitions. Each complete slot it keeps appears as a one-cycle `smp_valid` pulse. The pulse comes with a right-aligned sample and a flag that tells which slot the sample came from.

The framing follows run-time configuration inputs: data width, slot width, word-select polarity, the optional one-bit delay between a word-select change and the first data bit, bit order, and bit-clock inversion. A stereo/mono selector and a two-bit slot mask decide which slots become samples. Configuration is changed only while reset is asserted. If word-select changes before a slot has run its full length, the partial slot is dropped and a framing error is flagged.

Top module: `i2s_std_rx`

## Requirements
- R1: While reset is asserted and directly after it, `smp_valid`, `frame_err`, `smp_right` and `smp_data` are all zero.
- R2: `cfg_data_w` codes 0, 1, 2 and 3 select 8, 16, 24 and 32 data bits. The sample is right-aligned in `smp_data` and every bit above the data width is zero.
- R3: The slot length in bit clocks is the larger of the width coded by `cfg_slot_w` (same codes as R2) and the data width. Line bits that fall at or after the data width inside a slot do not affect the sample.
- R4: With `cfg_shift`=1, the first data bit of a slot is taken on the bit-clock edge after the edge at which word-select shows its new level. With `cfg_shift`=0 it is taken on that same edge.
- R5: With `cfg_ws_pol`=0 the left (first) slot is the one with word-select low. With `cfg_ws_pol`=1 it is the one with word-select high. `smp_right` is 0 for left-slot samples and 1 for right-slot samples.
- R6: With `cfg_lsb_first`=0 the first data bit of a slot is the sample MSB. With `cfg_lsb_first`=1 it is bit 0.
- R7: With `cfg_stereo`=1, every complete slot becomes a sample in line order (left, right, left, ...), whatever the value of `cfg_mask`.
- R8: With `cfg_stereo`=0, mask 2'b01 (bit 0 = left) keeps only left slots and mask 2'b10 (bit 1 = right) keeps only right slots.
- R9: With `cfg_stereo`=0, mask 2'b11 keeps both slots, as in stereo, and mask 2'b00 keeps no slot.
- R10: Each kept slot gives exactly one `smp_valid` pulse, one clock long.
- R11: If word-select changes after a slot has started but before it has run its full length, that slot gives no sample, `frame_err` pulses for one clock, and the change starts a new slot.
- R12: With `cfg_sck_inv`=1, bits are sampled on the falling edge of the bit-clock line instead of the rising edge.
- R13: Bits received after reset and before the first word-select transition give neither a sample nor a framing error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial bit clock from the line |
| ws_i | input | 1 | Word-select line |
| sd_i | input | 1 | Serial data line |
| cfg_data_w | input | 2 | Data width code (8/16/24/32) |
| cfg_slot_w | input | 2 | Slot width code (8/16/24/32), never below the data width |
| cfg_stereo | input | 1 | 1: keep all slots, 0: mono filtering by mask |
| cfg_mask | input | 2 | Mono slot mask, bit 0 left, bit 1 right |
| cfg_ws_pol | input | 1 | Word-select level of the left slot |
| cfg_shift | input | 1 | One-bit delay between word-select change and first data bit |
| cfg_lsb_first | input | 1 | First received bit is sample bit 0 |
| cfg_sck_inv | input | 1 | Sample on the falling line edge |
| smp_valid | output | 1 | One-cycle sample strobe |
| smp_data | output | MAX_W | Right-aligned sample |
| smp_right | output | 1 | Sample came from the right slot |
| frame_err | output | 1 | One-cycle pulse on a short slot |

## Verification
The stimulus covers both settings of the delayed-start option. A receiver that got the one-bit delay wrong would shift every sample by one position and carry a bit into the neighbouring slot. The stimulus also pads slots wider than the data with ones. A design that did not stop assembling at the data width would let those ones into the low bits of the sample, or into bits above it. A short slot in mid-stream checks that the partial word is dropped rather than emitted truncated, and that the slots after it stay in step. The mono masks, including the both-slots and empty cases, catch a filter that keys on the wrong slot or on the line level instead of the polarity-adjusted slot.

// File: rtl/i2srx_pkg.sv
package i2srx_pkg;

   localparam int IDX_W = 6;

   // per-bit event handed from the framer to the assembler
   typedef struct packed {
      logic             stb;
      logic             sd;
      logic             right;
      logic             last;
      logic [IDX_W-1:0] idx;
   } bit_evt_t;

   // width code 0..3 -> 8, 16, 24, 32 bits
   function automatic logic [IDX_W-1:0] dw_bits(input logic [1:0] code);
      return {1'b0, code, 3'b000} + 6'd8;
   endfunction

endpackage

// File: rtl/i2srx_sync.sv
module i2srx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_i,
   input  logic ws_i,
   input  logic sd_i,
   input  logic sck_inv,
   output logic bit_stb,
   output logic ws_bit,
   output logic sd_bit
);
   localparam int LINES = 3;

   logic [STAGES-1:0][LINES-1:0] chain;
   logic                         sck_last;
   logic                         sck_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= {sck_i, ws_i, sd_i};
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign sck_now = chain[STAGES-1][2] ^ sck_inv;

   // reset high so that no edge is seen in the first cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_last <= 1'b1;
      else        sck_last <= sck_now;
   end

   assign bit_stb = sck_now & ~sck_last;
   assign ws_bit  = chain[STAGES-1][1];
   assign sd_bit  = chain[STAGES-1][0];

endmodule

// File: rtl/i2srx_framer.sv
module i2srx_framer
   import i2srx_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_stb,
   input  logic             ws_bit,
   input  logic             sd_bit,
   input  logic             cfg_shift,
   input  logic             cfg_ws_pol,
   input  logic [IDX_W-1:0] slot_bits,
   output bit_evt_t         evt,
   output logic             err_p
);
   localparam logic [1:0] PRIME_DONE = 2'd2;

   logic             ws_d;
   logic             prev_eff;
   logic [1:0]       prime;
   logic             locked;
   logic [IDX_W-1:0] cnt;
   logic             cur_right;

   logic             eff;
   logic             primed;
   logic             bound;
   logic             in_slot;
   logic [IDX_W-1:0] idx_now;

   // the one-bit delay is applied by lagging word-select by one bit
   assign eff     = cfg_shift ? ws_d : ws_bit;
   assign primed  = (prime == PRIME_DONE);
   assign bound   = bit_stb && primed && (eff != prev_eff);
   assign in_slot = locked && (cnt != '0) && (cnt < slot_bits);
   assign idx_now = bound ? '0 : cnt;

   always_comb begin
      evt.stb   = bit_stb && primed && (bound || in_slot);
      evt.sd    = sd_bit;
      evt.idx   = idx_now;
      evt.right = bound ? (eff ^ cfg_ws_pol) : cur_right;
      evt.last  = evt.stb && (idx_now == slot_bits - 6'd1);
   end

   assign err_p = bound && in_slot;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ws_d      <= 1'b0;
         prev_eff  <= 1'b0;
         prime     <= '0;
         locked    <= 1'b0;
         cnt       <= '0;
         cur_right <= 1'b0;
      end else if (bit_stb) begin
         ws_d     <= ws_bit;
         prev_eff <= eff;
         if (!primed) prime <= prime + 2'd1;
         if (bound) begin
            locked    <= 1'b1;
            cnt       <= 6'd1;
            cur_right <= eff ^ cfg_ws_pol;
         end else if (in_slot) begin
            cnt <= cnt + 6'd1;
         end
      end
   end

endmodule

// File: rtl/i2srx_assemble.sv
module i2srx_assemble
   import i2srx_pkg::*;
#(
   parameter int MAX_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  bit_evt_t         evt,
   input  logic [IDX_W-1:0] data_bits,
   input  logic             lsb_first,
   output logic             done,
   output logic [MAX_W-1:0] word,
   output logic             word_right
);
   logic [MAX_W-1:0] acc;
   logic [MAX_W-1:0] base;
   logic [MAX_W-1:0] msb_ins;
   logic [MAX_W-1:0] lsb_ins;
   logic [MAX_W-1:0] nxt;
   logic             take;

   assign base    = (evt.idx == '0) ? '0 : acc;
   assign take    = evt.idx < data_bits;
   assign msb_ins = {base[MAX_W-2:0], evt.sd};

   for (genvar b = 0; b < MAX_W; b++) begin : g_lsb
      assign lsb_ins[b] = (int'(evt.idx) == b) ? evt.sd : base[b];
   end

   assign nxt = !take ? base : (lsb_first ? lsb_ins : msb_ins);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       acc <= '0;
      else if (evt.stb) acc <= nxt;
   end

   assign done       = evt.last;
   assign word       = nxt;
   assign word_right = evt.right;

endmodule

// File: rtl/i2srx_select.sv
module i2srx_select #(
   parameter int MAX_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done,
   input  logic [MAX_W-1:0] word,
   input  logic             word_right,
   input  logic             err_p,
   input  logic             stereo,
   input  logic [1:0]       mask,
   output logic             smp_valid,
   output logic [MAX_W-1:0] smp_data,
   output logic             smp_right,
   output logic             frame_err
);
   logic keep;

   assign keep = stereo | (mask[0] & ~word_right) | (mask[1] & word_right);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_valid <= 1'b0;
         smp_data  <= '0;
         smp_right <= 1'b0;
         frame_err <= 1'b0;
      end else begin
         smp_valid <= done & keep;
         frame_err <= err_p;
         if (done & keep) begin
            smp_data  <= word;
            smp_right <= word_right;
         end
      end
   end

endmodule

// File: rtl/i2s_std_rx.sv
module i2s_std_rx
   import i2srx_pkg::*;
#(
   parameter int MAX_W       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sck_i,
   input  logic             ws_i,
   input  logic             sd_i,
   input  logic [1:0]       cfg_data_w,
   input  logic [1:0]       cfg_slot_w,
   input  logic             cfg_stereo,
   input  logic [1:0]       cfg_mask,
   input  logic             cfg_ws_pol,
   input  logic             cfg_shift,
   input  logic             cfg_lsb_first,
   input  logic             cfg_sck_inv,
   output logic             smp_valid,
   output logic [MAX_W-1:0] smp_data,
   output logic             smp_right,
   output logic             frame_err
);
   if (MAX_W < 32 || MAX_W > 63) begin : g_bad_width
      $error("i2s_std_rx: MAX_W must lie in 32..63");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("i2s_std_rx: SYNC_STAGES must be at least 2");
   end

   logic             bit_stb, ws_bit, sd_bit;
   logic [IDX_W-1:0] data_bits, slot_code_bits, slot_bits;
   bit_evt_t         evt;
   logic             err_p;
   logic             done;
   logic [MAX_W-1:0] word;
   logic             word_right;

   assign data_bits      = dw_bits(cfg_data_w);
   assign slot_code_bits = dw_bits(cfg_slot_w);
   assign slot_bits      = (slot_code_bits > data_bits) ? slot_code_bits : data_bits;

   i2srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .sck_i   (sck_i),
      .ws_i    (ws_i),
      .sd_i    (sd_i),
      .sck_inv (cfg_sck_inv),
      .bit_stb (bit_stb),
      .ws_bit  (ws_bit),
      .sd_bit  (sd_bit)
   );

   i2srx_framer u_framer (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_stb    (bit_stb),
      .ws_bit     (ws_bit),
      .sd_bit     (sd_bit),
      .cfg_shift  (cfg_shift),
      .cfg_ws_pol (cfg_ws_pol),
      .slot_bits  (slot_bits),
      .evt        (evt),
      .err_p      (err_p)
   );

   i2srx_assemble #(.MAX_W(MAX_W)) u_asm (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt        (evt),
      .data_bits  (data_bits),
      .lsb_first  (cfg_lsb_first),
      .done       (done),
      .word       (word),
      .word_right (word_right)
   );

   i2srx_select #(.MAX_W(MAX_W)) u_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .done       (done),
      .word       (word),
      .word_right (word_right),
      .err_p      (err_p),
      .stereo     (cfg_stereo),
      .mask       (cfg_mask),
      .smp_valid  (smp_valid),
      .smp_data   (smp_data),
      .smp_right  (smp_right),
      .frame_err  (frame_err)
   );

endmodule

// File: rtl/i2s_std_rx_chk.sv
module i2s_std_rx_chk
   import i2srx_pkg::*;
#(
   parameter int MAX_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       cfg_data_w,
   input logic             cfg_stereo,
   input logic [1:0]       cfg_mask,
   input logic             smp_valid,
   input logic [MAX_W-1:0] smp_data,
   input logic             smp_right,
   input logic             frame_err
);
   logic have_prev, prev_right, err_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_prev  <= 1'b0;
         prev_right <= 1'b0;
         err_seen   <= 1'b0;
      end else begin
         if (frame_err) err_seen <= 1'b1;
         if (smp_valid) begin
            have_prev  <= 1'b1;
            prev_right <= smp_right;
         end
      end
   end

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |-> ((smp_data >> dw_bits(cfg_data_w)) == '0))
      else $error("upper sample bits not zero"); // R2

   AST_STEREO_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_stereo && smp_valid && have_prev && !err_seen && !frame_err) |-> (smp_right != prev_right))
      else $error("stereo samples out of line order"); // R7

   AST_MONO_LEFT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && !cfg_stereo && cfg_mask == 2'b01) |-> !smp_right)
      else $error("right sample in mono-left"); // R8

   AST_MONO_RIGHT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && !cfg_stereo && cfg_mask == 2'b10) |-> smp_right)
      else $error("left sample in mono-right"); // R8

   AST_MONO_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_stereo && cfg_mask == 2'b00) |-> !smp_valid)
      else $error("sample with empty mask"); // R9

   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> !smp_valid)
      else $error("valid longer than one cycle"); // R10

   AST_ERR_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> !smp_valid)
      else $error("sample together with framing error"); // R11

   AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> !frame_err)
      else $error("framing error longer than one cycle"); // R11

endmodule

bind i2s_std_rx i2s_std_rx_chk #(.MAX_W(MAX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_data_w (cfg_data_w),
   .cfg_stereo (cfg_stereo),
   .cfg_mask   (cfg_mask),
   .smp_valid  (smp_valid),
   .smp_data   (smp_data),
   .smp_right  (smp_right),
   .frame_err  (frame_err)
);

// File: tb/tb_i2s_std_rx.sv
`timescale 1ns/1ps
module tb_i2s_std_rx;
   localparam int HB = 4;
   localparam int WDOG = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sck_l = 1'b0, inv_b = 1'b0;
   logic sck_i, ws_i = 1'b0, sd_i = 1'b0;
   logic [1:0] cfg_data_w = 2'd1, cfg_slot_w = 2'd1, cfg_mask = 2'b11;
   logic cfg_stereo = 1'b1, cfg_ws_pol = 1'b0, cfg_shift = 1'b1, cfg_lsb_first = 1'b0;
   logic smp_valid, smp_right, frame_err;
   logic [31:0] smp_data;

   assign sck_i = sck_l ^ inv_b;

   always #10 clk = ~clk;

   i2s_std_rx dut (
      .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .ws_i(ws_i), .sd_i(sd_i),
      .cfg_data_w(cfg_data_w), .cfg_slot_w(cfg_slot_w), .cfg_stereo(cfg_stereo),
      .cfg_mask(cfg_mask), .cfg_ws_pol(cfg_ws_pol), .cfg_shift(cfg_shift),
      .cfg_lsb_first(cfg_lsb_first), .cfg_sck_inv(inv_b),
      .smp_valid(smp_valid), .smp_data(smp_data), .smp_right(smp_right),
      .frame_err(frame_err)
   );

   int n_chk = 0, n_bad = 0, err_cnt = 0, cyc = 0;
   string cur_tag = "R1";
   logic [31:0] exp_d[$];
   bit exp_r[$];
   bit lvl_q[$];
   bit sd_q[$];
   bit prev_v = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // reference: compare every strobe against the expected queue
   always @(negedge clk) begin
      if (rst_n) begin
         if (smp_valid) begin
            chk(!prev_v, "R10", "valid held two cycles", 64'(prev_v), 64'd0);
            if (exp_d.size() == 0) begin
               chk(1'b0, cur_tag, "unexpected sample", 64'(smp_data), 64'd0);
            end else begin
               logic [31:0] ed;
               bit er;
               ed = exp_d.pop_front();
               er = exp_r.pop_front();
               chk(smp_data == ed, cur_tag, "sample data", 64'(smp_data), 64'(ed));
               chk(smp_right == er, cur_tag, "sample side", 64'(smp_right), 64'(er));
            end
         end
         if (frame_err) err_cnt++;
         prev_v = smp_valid;
      end else begin
         prev_v = 1'b0;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == WDOG) begin
         n_bad++;
         $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WDOG);
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   task automatic drive_bit(input bit w, input bit d);
      sck_l = 1'b0;
      ws_i = w;
      sd_i = d;
      repeat (HB) @(negedge clk);
      sck_l = 1'b1;
      repeat (HB) @(negedge clk);
   endtask

   task automatic run_test(input string tag, input logic [1:0] dc, input logic [1:0] sc,
                           input bit st, input logic [1:0] mk, input bit pol, input bit sh,
                           input bit lsb, input bit inv, input int nslots, input int short_idx);
      int dbits, sbits, n;
      logic [31:0] dmask;
      bit lead;
      cur_tag = tag;
      @(negedge clk);
      rst_n = 1'b0;
      sck_l = 1'b0;
      cfg_data_w = dc; cfg_slot_w = sc; cfg_stereo = st; cfg_mask = mk;
      cfg_ws_pol = pol; cfg_shift = sh; cfg_lsb_first = lsb; inv_b = inv;
      exp_d.delete(); exp_r.delete(); lvl_q.delete(); sd_q.delete();
      err_cnt = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      dbits = 8 * (int'(dc) + 1);
      sbits = 8 * (int'(sc) + 1);
      if (sbits < dbits) sbits = dbits;
      dmask = 32'((64'd1 << dbits) - 64'd1);
      lead = ~pol;
      // lead-in bits before any transition, garbage data (R13)
      for (int i = 0; i < 3; i++) begin lvl_q.push_back(lead); sd_q.push_back(1'b1); end
      for (int k = 0; k < nslots; k++) begin
         bit right, lvl, keep;
         logic [31:0] v;
         right = bit'(k % 2);
         lvl = right ^ pol;
         v = (32'h6A09_E667 ^ (32'(k) * 32'h3C6E_F372)) + 32'(dc);
         n = (k == short_idx) ? 5 : sbits;
         for (int i = 0; i < n; i++) begin
            lvl_q.push_back(lvl);
            if (i < dbits) sd_q.push_back(lsb ? v[i] : v[dbits-1-i]);
            else           sd_q.push_back(1'b1);
         end
         keep = st || (mk[0] && !right) || (mk[1] && right);
         if (keep && n == sbits) begin
            exp_d.push_back(v & dmask);
            exp_r.push_back(right);
         end
      end
      lead = ~lvl_q[lvl_q.size()-1];
      for (int i = 0; i < 3; i++) begin lvl_q.push_back(lead); sd_q.push_back(1'b0); end
      for (int t = 0; t < lvl_q.size(); t++) begin
         int tw;
         tw = sh ? ((t + 1 < lvl_q.size()) ? t + 1 : t) : t;
         drive_bit(lvl_q[tw], sd_q[t]);
      end
      repeat (30) @(negedge clk);
      chk(exp_d.size() == 0, tag, "samples missing at end", 64'(exp_d.size()), 64'd0);
      chk(err_cnt == ((short_idx >= 0) ? 1 : 0), "R11 R13", "framing error count",
          64'(err_cnt), 64'((short_idx >= 0) ? 1 : 0));
   endtask

   initial begin
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      // R1: outputs cleared in and after reset
      chk(smp_valid == 1'b0 && frame_err == 1'b0, "R1", "flags in reset",
          64'({smp_valid, frame_err}), 64'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(smp_data == '0 && smp_right == 1'b0 && smp_valid == 1'b0, "R1", "outputs after reset",
          64'({smp_valid, smp_right, smp_data}), 64'd0);
      //       tag        dc    sc    st  mask   pol sh lsb inv n  short
      run_test("R7 R4",   2'd1, 2'd0, 1, 2'b11, 0, 1, 0, 0, 6, -1);
      run_test("R7",      2'd1, 2'd1, 1, 2'b01, 0, 1, 0, 0, 6, -1);
      run_test("R8 R3",   2'd2, 2'd3, 0, 2'b01, 0, 1, 0, 0, 6, -1);
      run_test("R8 R4 R2",2'd0, 2'd0, 0, 2'b10, 0, 0, 0, 0, 6, -1);
      run_test("R9",      2'd1, 2'd1, 0, 2'b11, 0, 1, 0, 0, 6, -1);
      run_test("R9",      2'd1, 2'd1, 0, 2'b00, 0, 1, 0, 0, 6, -1);
      run_test("R5",      2'd1, 2'd1, 1, 2'b11, 1, 1, 0, 0, 6, -1);
      run_test("R6 R2",   2'd3, 2'd0, 1, 2'b11, 0, 1, 1, 0, 4, -1);
      run_test("R12",     2'd1, 2'd1, 1, 2'b11, 0, 0, 0, 1, 6, -1);
      run_test("R11",     2'd1, 2'd1, 1, 2'b11, 0, 1, 0, 0, 6, 2);
      run_test("R3",      2'd2, 2'd0, 1, 2'b11, 0, 0, 0, 0, 4, -1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule